// File: doc/BRIEF.md
# Interlaced Display Window Fetch Address Generator

This block walks the active display window of a framebuffer and issues one 32-bit word address per fetch. Software programs two field start addresses (one for the long field, one for the short field), a packed window-size word that holds the row width, the row count and a line modulo, and an interlace enable. A field-start pulse comes from vertical retrace. At that pulse the block picks the start address for the new field and loads it. It also captures the window geometry for the whole field.

Within a row, each accepted fetch advances the address by one word. On the last word of a row, the address instead advances by the modulo. A modulo of 1 makes rows contiguous. In interlaced operation the modulo is set to 1 plus one full line in words, so each field reads every other line of a progressive buffer. The short-field start is then placed one line after the long-field start. The row count is half the vertical resolution. The consumer raises a request whenever it can take a word, and the block answers with a valid strobe, the address, and end-of-row and end-of-field flags.

Top module: `field_fetch_addr_gen`

## Requirements
- R1: While reset is held, and after its release until the first field start, `fetch_valid`, `row_end` and `field_end` are 0, even when `fetch_req` is 1.
- R2: In the cycle after `field_start`, `fetch_addr` equals the `long_base` value present at the pulse when the new field is even (`field_odd` = 0), and equals the `short_base` value present at the pulse when it is odd.
- R3: With `interlace` high at the pulse, field parity alternates at each field start: the first field after reset is even. With `interlace` low, the field is even and the parity restarts, so the next interlaced field is even again.
- R4: Each accepted fetch that is not the last word of a row advances `fetch_addr` by exactly 1 word. While `fetch_req` is 0, `fetch_addr` holds its value.
- R5: The fetch on the last word of a row is followed by `fetch_addr` advancing by the modulo, which is `win_size[29:20]`. The word at row r, column c is base + r*(width_m1 + modulo) + c.
- R6: `row_end` is 1 exactly on the fetch whose column index equals `win_size[9:0]`, so a row holds `win_size[9:0]`+1 words.
- R7: `field_end` is 1 exactly on the last word of row `win_size[19:10]`, so a field holds `win_size[19:10]`+1 rows. After it, `fetch_valid` stays 0 until the next `field_start`.
- R8: Changes to `long_base`, `short_base`, `win_size` or `interlace` between field starts have no effect on the address sequence of the current field.
- R9: `fetch_valid` equals `fetch_req` while a field is in progress and no `field_start` is present.
- R10: A `field_start` in the middle of a field abandons it and restarts from the start address of the next parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | One-cycle pulse at vertical retrace; starts a field |
| interlace | input | 1 | 1 selects interlaced operation for the field that starts |
| long_base | input | ADDR_W | Word address where the long (even) field begins |
| short_base | input | ADDR_W | Word address where the short (odd) field begins |
| win_size | input | 3*FIELD_W | {modulo, rows minus one, width in words minus one} |
| fetch_req | input | 1 | Consumer can accept a word this cycle |
| fetch_addr | output | ADDR_W | Current word address |
| fetch_valid | output | 1 | A fetch is issued this cycle at `fetch_addr` |
| row_end | output | 1 | This fetch is the last word of its row |
| field_end | output | 1 | This fetch is the last word of the field |
| field_odd | output | 1 | Parity of the field in progress |

## Verification
The assertions assume that `field_start` is a single-cycle pulse and that the programmed modulo is at least 1. They also assume that `fetch_addr` plus the window extent stays within the address width, so no wrap occurs. The stimulus programs only small windows (up to four words by three rows) with modulo values of 1, 4 and 9. It places bases far below the top of the address space, and it drives `field_start` only as isolated pulses, with `fetch_req` held low in the pulse cycle.

// File: rtl/fag_pkg.sv
package fag_pkg;
   localparam int unsigned DEF_ADDR_W  = 16;
   localparam int unsigned DEF_FIELD_W = 10;
   // lane order within the window-size word, lowest lane first
   localparam int unsigned LANE_WIDTH  = 0;
   localparam int unsigned LANE_ROWS   = 1;
   localparam int unsigned LANE_MOD    = 2;
   localparam int unsigned NUM_LANES   = 3;
endpackage

// File: rtl/fag_field_sel.sv
module fag_field_sel #(
   parameter int unsigned ADDR_W       = 16,
   parameter bit          INTERLACE_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              interlace,
   input  logic [ADDR_W-1:0] long_base,
   input  logic [ADDR_W-1:0] short_base,
   output logic [ADDR_W-1:0] sel_base,
   output logic              field_odd
);
   generate
      if (INTERLACE_OK) begin : g_ilace
         logic next_odd_q;
         logic odd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               next_odd_q <= 1'b0;
               odd_q      <= 1'b0;
            end else if (start) begin
               odd_q      <= interlace & next_odd_q;
               next_odd_q <= interlace & ~next_odd_q;
            end
         end
         assign sel_base  = (interlace && next_odd_q) ? short_base : long_base;
         assign field_odd = odd_q;
      end else begin : g_prog
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ start ^ interlace ^ (^short_base);
         assign sel_base  = long_base;
         assign field_odd = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fag_scan_ctr.sv
module fag_scan_ctr #(
   parameter int unsigned FIELD_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               step,
   input  logic [FIELD_W-1:0] width_m1,
   input  logic [FIELD_W-1:0] rows_m1,
   output logic               active,
   output logic               last_col,
   output logic               last_row
);
   logic [FIELD_W-1:0] col_q, row_q, wlim_q, rlim_q;
   logic               act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         wlim_q <= '0;
         rlim_q <= '0;
         act_q  <= 1'b0;
      end else if (start) begin
         col_q  <= '0;
         row_q  <= '0;
         wlim_q <= width_m1;
         rlim_q <= rows_m1;
         act_q  <= 1'b1;
      end else if (step && act_q) begin
         if (col_q == wlim_q) begin
            col_q <= '0;
            if (row_q == rlim_q) act_q <= 1'b0;
            else                 row_q <= row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   assign active   = act_q;
   assign last_col = (col_q == wlim_q);
   assign last_row = (row_q == rlim_q);
endmodule

// File: rtl/fag_addr_acc.sv
module fag_addr_acc #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned FIELD_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               step,
   input  logic               row_wrap,
   input  logic [ADDR_W-1:0]  base,
   input  logic [FIELD_W-1:0] modulo,
   output logic [ADDR_W-1:0]  addr,
   output logic [FIELD_W-1:0] mod_lat
);
   localparam int unsigned PAD_W = ADDR_W - FIELD_W;

   logic [ADDR_W-1:0]  addr_q;
   logic [FIELD_W-1:0] mod_q;
   logic [ADDR_W-1:0]  stride;

   assign stride = row_wrap ? {{PAD_W{1'b0}}, mod_q} : {{(ADDR_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         mod_q  <= '0;
      end else if (start) begin
         addr_q <= base;
         mod_q  <= modulo;
      end else if (step) begin
         addr_q <= addr_q + stride;
      end
   end

   assign addr    = addr_q;
   assign mod_lat = mod_q;
endmodule

// File: rtl/field_fetch_addr_gen.sv
module field_fetch_addr_gen #(
   parameter int unsigned ADDR_W       = fag_pkg::DEF_ADDR_W,
   parameter int unsigned FIELD_W      = fag_pkg::DEF_FIELD_W,
   parameter bit          INTERLACE_OK = 1'b1,
   localparam int unsigned WIN_W       = fag_pkg::NUM_LANES * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              interlace,
   input  logic [ADDR_W-1:0] long_base,
   input  logic [ADDR_W-1:0] short_base,
   input  logic [WIN_W-1:0]  win_size,
   input  logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_valid,
   output logic              row_end,
   output logic              field_end,
   output logic              field_odd
);
   generate
      if (FIELD_W < 2) begin : g_bad_field
         $error("FIELD_W must be at least 2");
      end
      if (ADDR_W <= FIELD_W) begin : g_bad_addr
         $error("ADDR_W must exceed FIELD_W");
      end
   endgenerate

   logic [FIELD_W-1:0] w_width, w_rows, w_mod, mod_q;
   logic [ADDR_W-1:0]  sel_base;
   logic               active, last_col, last_row, step;

   assign w_width = win_size[fag_pkg::LANE_WIDTH*FIELD_W +: FIELD_W];
   assign w_rows  = win_size[fag_pkg::LANE_ROWS*FIELD_W  +: FIELD_W];
   assign w_mod   = win_size[fag_pkg::LANE_MOD*FIELD_W   +: FIELD_W];

   fag_field_sel #(.ADDR_W(ADDR_W), .INTERLACE_OK(INTERLACE_OK)) u_sel (
      .clk(clk), .rst_n(rst_n), .start(field_start), .interlace(interlace),
      .long_base(long_base), .short_base(short_base),
      .sel_base(sel_base), .field_odd(field_odd));

   fag_scan_ctr #(.FIELD_W(FIELD_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start(field_start), .step(step),
      .width_m1(w_width), .rows_m1(w_rows),
      .active(active), .last_col(last_col), .last_row(last_row));

   fag_addr_acc #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .start(field_start), .step(step),
      .row_wrap(last_col), .base(sel_base), .modulo(w_mod),
      .addr(fetch_addr), .mod_lat(mod_q));

   assign step        = active & fetch_req & ~field_start;
   assign fetch_valid = step;
   assign row_end     = step & last_col;
   assign field_end   = step & last_col & last_row;
endmodule

// File: rtl/fag_checker.sv
module fag_checker #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned FIELD_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               field_start,
   input logic               interlace,
   input logic               fetch_req,
   input logic [ADDR_W-1:0]  long_base,
   input logic [ADDR_W-1:0]  short_base,
   input logic [ADDR_W-1:0]  fetch_addr,
   input logic               fetch_valid,
   input logic               row_end,
   input logic               field_end,
   input logic               field_odd,
   input logic [FIELD_W-1:0] mod_q
);
   a_r2_base_load: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> fetch_addr == (field_odd ? $past(short_base) : $past(long_base)));

   a_r3_prog_even: assert property (@(posedge clk) disable iff (!rst_n)
      (field_start && !interlace) |=> !field_odd);

   a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !row_end && !field_start) |=> fetch_addr == $past(fetch_addr) + 1'b1);

   a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid && !field_start) |=> $stable(fetch_addr));

   a_r5_row_stride: assert property (@(posedge clk) disable iff (!rst_n)
      (row_end && !field_end && !field_start) |=>
         fetch_addr == $past(fetch_addr) + {{(ADDR_W-FIELD_W){1'b0}}, mod_q});

   a_r7_end_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      field_end |-> row_end);

   a_r7_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
      (field_end && !field_start) |=> !fetch_valid);

   a_r9_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid || row_end) |-> (fetch_req && !field_start && fetch_valid));
endmodule

bind field_fetch_addr_gen fag_checker #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_fag_chk (
   .clk(clk), .rst_n(rst_n), .field_start(field_start), .interlace(interlace),
   .fetch_req(fetch_req), .long_base(long_base), .short_base(short_base),
   .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .row_end(row_end),
   .field_end(field_end), .field_odd(field_odd), .mod_q(mod_q));

// File: tb/test_field_fetch_addr_gen.sv
module test_field_fetch_addr_gen;
   localparam int AW = 16;
   localparam int FW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          field_start = 1'b0;
   logic          interlace = 1'b0;
   logic [AW-1:0] long_base = '0;
   logic [AW-1:0] short_base = '0;
   logic [3*FW-1:0] win_size = '0;
   logic          fetch_req = 1'b0;
   logic [AW-1:0] fetch_addr;
   logic          fetch_valid, row_end, field_end, field_odd;

   int n_tests = 0;
   int n_fail  = 0;
   bit next_odd = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   field_fetch_addr_gen i_field_fetch_addr_gen (
      .clk(clk), .rst_n(rst_n), .field_start(field_start), .interlace(interlace),
      .long_base(long_base), .short_base(short_base), .win_size(win_size),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
      .row_end(row_end), .field_end(field_end), .field_odd(field_odd));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
      end
   end

   // start a field; returns the expected base and parity
   task automatic begin_field(input bit il, input int lb, input int sb,
                              input int w, input int r, input int m,
                              output int base, output bit odd);
      @(negedge clk);
      interlace   = il;
      long_base   = AW'(lb);
      short_base  = AW'(sb);
      win_size    = {FW'(m), FW'(r), FW'(w)};
      fetch_req   = 1'b0;
      field_start = 1'b1;
      odd  = il & next_odd;
      next_odd = il & ~next_odd;
      base = odd ? sb : lb;
      @(negedge clk);
      field_start = 1'b0;
      // R8: scramble programming inputs mid-field
      long_base  = ~AW'(lb);
      short_base = ~AW'(sb);
      win_size   = {FW'(m + 3), FW'(r + 2), FW'(w + 5)};
      interlace  = ~il;
      #1;
      chk("R3 field parity", 32'(field_odd), 32'(odd));
      chk("R2 base loaded", 32'(fetch_addr), 32'(base));
   endtask

   task automatic run_field(input bit il, input int lb, input int sb,
                            input int w, input int r, input int m);
      int base;
      bit odd;
      int k = 0;
      begin_field(il, lb, sb, w, r, m, base, odd);
      for (int rr = 0; rr <= r; rr++) begin
         for (int cc = 0; cc <= w; cc++) begin
            int exp_a = base + rr * (w + m) + cc;
            if ((k % 3) == 2) begin
               fetch_req = 1'b0;
               #1;
               chk("R4 hold without request", 32'(fetch_addr), 32'(exp_a & 16'hFFFF));
               chk("R9 no valid without request", 32'(fetch_valid), 0);
               @(negedge clk);
            end
            k++;
            fetch_req = 1'b1;
            #1;
            chk("R5 R8 address", 32'(fetch_addr), 32'(exp_a & 16'hFFFF));
            chk("R9 valid", 32'(fetch_valid), 1);
            chk("R6 row end", 32'(row_end), 32'(cc == w));
            chk("R7 field end", 32'(field_end), 32'((cc == w) && (rr == r)));
            @(negedge clk);
         end
      end
      fetch_req = 1'b1;
      #1;
      chk("R7 idle after field", 32'(fetch_valid), 0);
      fetch_req = 1'b0;
   endtask

   initial begin
      int base;
      bit odd;
      fetch_req = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 valid in reset", 32'(fetch_valid), 0);
      chk("R1 field end in reset", 32'(field_end), 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      #1;
      chk("R1 valid after reset", 32'(fetch_valid), 0);
      chk("R1 row end after reset", 32'(row_end), 0);
      fetch_req = 1'b0;

      for (int il = 0; il < 2; il++)
         for (int w = 0; w < 4; w++)
            for (int r = 0; r < 3; r++)
               for (int mi = 0; mi < 3; mi++) begin
                  int m = (mi == 0) ? 1 : (mi == 1) ? 4 : 9;
                  int lb = 256 + 37 * (w + 4 * r);
                  for (int f = 0; f < 2; f++)
                     run_field(il[0], lb + f, lb + 1000 + w, w, r, m);
               end

      // R3: progressive field resets parity, next interlaced field is even
      run_field(1'b1, 500, 900, 1, 1, 1);
      run_field(1'b0, 600, 901, 1, 0, 1);
      begin_field(1'b1, 700, 902, 2, 1, 1, base, odd);
      chk("R3 even after progressive", 32'(field_odd), 0);

      // R10: restart mid-field
      fetch_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      fetch_req = 1'b0;
      begin_field(1'b1, 800, 1200, 2, 1, 1, base, odd);
      chk("R10 restart parity odd", 32'(field_odd), 1);
      chk("R10 restart base", 32'(fetch_addr), 1200);
      fetch_req = 1'b1;
      #1;
      chk("R10 restart valid", 32'(fetch_valid), 1);
      chk("R10 restart row end", 32'(row_end), 0);
      fetch_req = 1'b0;

      done = 1'b1;
      summary();
   end
endmodule